// File: doc/BRIEF.md
# Ping-Pong IN Endpoint Transmit Buffer

This block is the transmit side of one bulk or interrupt IN endpoint. It holds two packet banks, so firmware can fill one while the other waits for the host. Firmware pushes payload bytes into the bank under its write pointer and then arms that bank. Arming marks the bank ready to send and moves the write pointer to the other bank. Firmware may fill the second bank at once, even while the first is still waiting.

The packet engine raises an IN-token strobe. The block answers with a one-cycle NAK pulse when the bank under its read pointer is not armed. It answers with a one-cycle zero-length pulse when that bank is armed but empty. Otherwise it streams the bank's bytes, and the last byte is marked. A host ACK releases the bank, sets the transmit-complete flag (which drives the interrupt) and moves the read pointer. If no ACK arrives, the next IN token replays the same bank from its first byte.

Payload bytes enter on a valid/ready channel. Its ready is held high, so writes are never stalled: bytes beyond capacity, or bytes sent to an armed bank, are accepted and dropped. The outgoing stream is valid/ready. While ready is low, the block holds its valid, data and last values unchanged. Token, ACK, arm and clear inputs are single-cycle strobes.

Top module: `pp_in_endpoint`

## Requirements
- R1: After reset the ready-to-send flag, the complete flag, the overflow flag, the interrupt, the NAK and zero-length pulses, and the outgoing stream valid are all low.
- R2: Bytes written while the write bank is unarmed are stored in order and are streamed in that same order, up to BANK_BYTES (64) bytes per bank.
- R3: A write into an unarmed bank that already holds BANK_BYTES bytes is dropped and sets a sticky overflow flag. Only the overflow-clear strobe clears that flag, and the clear takes effect only in a cycle where no overflow occurs.
- R4: An arm strobe while the write bank is unarmed marks that bank armed and moves the write pointer to the other bank. The ready-to-send flag is high while any bank is armed. An arm strobe while the write bank is already armed is ignored.
- R5: An IN token while idle, with the read bank unarmed, gives exactly one NAK pulse in the cycle after the token.
- R6: An IN token with a non-empty armed read bank starts the stream in the cycle after the token. The last byte carries the last marker. Valid, data and last stay unchanged while stream ready is low.
- R7: An IN token with an armed, empty read bank gives one zero-length pulse in the cycle after the token, and no stream beat.
- R8: An ACK while waiting for acknowledgement releases the read bank, sets the complete flag and the interrupt, and moves the read pointer. The ready-to-send flag falls when no other bank is armed.
- R9: An IN token while waiting for acknowledgement replays the same bank from its first byte. An ACK at any other time is ignored.
- R10: The complete flag is cleared only by the clear strobe, and an ACK release in the same cycle wins. Clearing never disturbs an armed bank, whether the clear comes before or after the next arm.
- R11: Writes while the write bank is armed (both banks full) are dropped and do not alter either payload.
- R12: IN tokens that arrive while a packet is streaming are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_wr_valid | input | 1 | Payload byte valid |
| fw_wr_ready | output | 1 | Payload byte ready (held high) |
| fw_wr_data | input | 8 | Payload byte |
| fw_arm | input | 1 | Arm the bank under the write pointer |
| fw_clr_done | input | 1 | Clear the complete flag |
| fw_clr_ovf | input | 1 | Clear the overflow flag |
| st_pkt_ready | output | 1 | Some bank is armed |
| st_tx_done | output | 1 | A packet was acknowledged |
| st_overflow | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt, high while the complete flag is set |
| usb_in_tok | input | 1 | IN token strobe |
| usb_ack | input | 1 | Host ACK strobe |
| rsp_nak | output | 1 | NAK answer pulse |
| rsp_zlp | output | 1 | Zero-length answer pulse |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the packet |

## Verification
The bench fills the second bank while the first is pending. It clears the complete flag before the next arm. A design that tied the clear to the bank valid bits would then drop the armed packet and answer NAK. It also withholds the ACK and re-tokens. A design that released on the last beat, or resumed from the stall point, would stream the wrong bank or a truncated payload. Other cases covered: an empty armed bank, which must give a zero-length pulse and not a one-byte packet; a 70-byte fill, where a missing capacity check would wrap and corrupt the first bytes; writes and arms with both banks full; tokens mid-stream; and an ACK coinciding with a clear, where the wrong priority would hide a completion.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
  parameter int BANK_BYTES = 64,
  parameter int IDX_W      = $clog2(BANK_BYTES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wbank,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic             rbank,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  logic [7:0] bank_out [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [BANK_BYTES];
    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b))) mem[widx] <= wdata;
    end
    assign bank_out[b] = mem[ridx];
  end

  assign rdata = bank_out[rbank];
endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl #(
  parameter int BANK_BYTES = 64,
  parameter int IDX_W      = $clog2(BANK_BYTES),
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic                  arm,
  input  logic                  clr_ovf,
  input  logic [1:0]            bank_vld,
  input  logic                  rel,
  input  logic                  rel_bank,
  output logic                  mem_we,
  output logic                  mem_bank,
  output logic [IDX_W-1:0]      mem_idx,
  output logic [1:0][CNT_W-1:0] cnt,
  output logic                  arm_set,
  output logic                  arm_bank,
  output logic                  ovf
);
  logic wp;
  logic bank_free, room, ovf_hit;

  assign bank_free = !bank_vld[wp];
  assign room      = cnt[wp] < CNT_W'(BANK_BYTES);
  assign mem_we    = wr_valid && bank_free && room;
  assign ovf_hit   = wr_valid && bank_free && !room;
  assign mem_bank  = wp;
  assign mem_idx   = cnt[wp][IDX_W-1:0];
  assign arm_set   = arm && bank_free;
  assign arm_bank  = wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (arm_set) wp <= ~wp;
      if (ovf_hit) ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[b] <= '0;
      else if (rel && (rel_bank == 1'(b))) cnt[b] <= '0;
      else if (mem_we && (wp == 1'(b))) cnt[b] <= cnt[b] + 1'b1;
    end
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[b] <= CNT_W'(BANK_BYTES)); // R3
  end

  AST_ARM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> wp != $past(wp)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_ovf |=> ovf); // R3
endmodule

// File: rtl/pp_tx_engine.sv
module pp_tx_engine
  import pp_ep_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int IDX_W      = $clog2(BANK_BYTES),
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tok,
  input  logic                  ack,
  input  logic [1:0]            bank_vld,
  input  logic [1:0][CNT_W-1:0] cnt,
  input  logic                  tx_ready,
  output logic                  rd_bank,
  output logic [IDX_W-1:0]      rd_idx,
  output logic                  tx_valid,
  output logic                  tx_last,
  output logic                  rsp_nak,
  output logic                  rsp_zlp,
  output logic                  rel,
  output logic                  rel_bank
);
  tx_state_e        st, st_n;
  logic             rp, rp_n;
  logic [IDX_W-1:0] idx_n;
  logic             nak_n, zlp_n;
  logic [CNT_W-1:0] cur_cnt;

  assign cur_cnt  = cnt[rp];
  assign rd_bank  = rp;
  assign tx_valid = (st == TX_SEND);
  assign tx_last  = tx_valid && ((CNT_W'(rd_idx) + 1'b1) == cur_cnt);
  assign rel      = (st == TX_WAIT) && ack;
  assign rel_bank = rp;

  always_comb begin
    st_n  = st;
    rp_n  = rp;
    idx_n = rd_idx;
    nak_n = 1'b0;
    zlp_n = 1'b0;
    case (st)
      TX_IDLE, TX_WAIT: begin
        if (rel) begin
          st_n = TX_IDLE;
          rp_n = ~rp;
        end else if (tok) begin
          if (bank_vld[rp]) begin
            idx_n = '0;
            if (cur_cnt == '0) begin
              zlp_n = 1'b1;
              st_n  = TX_WAIT;
            end else begin
              st_n = TX_SEND;
            end
          end else begin
            nak_n = 1'b1;
          end
        end
      end
      TX_SEND: begin
        if (tx_ready) begin
          if (tx_last) st_n = TX_WAIT;
          else idx_n = rd_idx + 1'b1;
        end
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      rp      <= 1'b0;
      rd_idx  <= '0;
      rsp_nak <= 1'b0;
      rsp_zlp <= 1'b0;
    end else begin
      st      <= st_n;
      rp      <= rp_n;
      rd_idx  <= idx_n;
      rsp_nak <= nak_n;
      rsp_zlp <= zlp_n;
    end
  end

  AST_NAK_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nak |-> !$past(bank_vld[rp])); // R5
  AST_SEND_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> bank_vld[rp]); // R6
  AST_REL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> rp != $past(rp)); // R8
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_nak, rsp_zlp, tx_valid}) <= 1); // R7
endmodule

// File: rtl/pp_in_endpoint.sv
module pp_in_endpoint #(
  parameter int BANK_BYTES = 64,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fw_wr_valid,
  output logic       fw_wr_ready,
  input  logic [7:0] fw_wr_data,
  input  logic       fw_arm,
  input  logic       fw_clr_done,
  input  logic       fw_clr_ovf,
  output logic       st_pkt_ready,
  output logic       st_tx_done,
  output logic       st_overflow,
  output logic       irq,
  input  logic       usb_in_tok,
  input  logic       usb_ack,
  output logic       rsp_nak,
  output logic       rsp_zlp,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_last
);
  logic [1:0]            bank_vld;
  logic [1:0][CNT_W-1:0] cnt;
  logic                  mem_we, mem_bank, arm_set, arm_bank;
  logic [IDX_W-1:0]      mem_idx, rd_idx;
  logic                  rd_bank, rel, rel_bank;
  logic                  done;

  pp_fill_ctrl #(.BANK_BYTES(BANK_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_valid(fw_wr_valid), .arm(fw_arm),
    .clr_ovf(fw_clr_ovf), .bank_vld(bank_vld), .rel(rel), .rel_bank(rel_bank),
    .mem_we(mem_we), .mem_bank(mem_bank), .mem_idx(mem_idx), .cnt(cnt),
    .arm_set(arm_set), .arm_bank(arm_bank), .ovf(st_overflow)
  );

  pp_bank_mem #(.BANK_BYTES(BANK_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .wbank(mem_bank), .widx(mem_idx),
    .wdata(fw_wr_data), .rbank(rd_bank), .ridx(rd_idx), .rdata(tx_data)
  );

  pp_tx_engine #(.BANK_BYTES(BANK_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .tok(usb_in_tok), .ack(usb_ack),
    .bank_vld(bank_vld), .cnt(cnt), .tx_ready(tx_ready),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .tx_valid(tx_valid), .tx_last(tx_last),
    .rsp_nak(rsp_nak), .rsp_zlp(rsp_zlp), .rel(rel), .rel_bank(rel_bank)
  );

  for (genvar b = 0; b < 2; b++) begin : g_vld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_vld[b] <= 1'b0;
      else if (arm_set && (arm_bank == 1'(b))) bank_vld[b] <= 1'b1;
      else if (rel && (rel_bank == 1'(b))) bank_vld[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else if (rel) done <= 1'b1;
    else if (fw_clr_done) done <= 1'b0;
  end

  assign fw_wr_ready  = 1'b1;
  assign st_pkt_ready = |bank_vld;
  assign st_tx_done   = done;
  assign irq          = done;

  AST_DONE_ON_REL: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> st_tx_done && irq); // R8
  AST_ARM_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> bank_vld[$past(arm_bank)]); // R4
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R6
  AST_CLR_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    fw_clr_done && !rel |=> (($past(bank_vld) & ~bank_vld) == 2'b00)); // R10
endmodule

// File: tb/tb_pp_in_endpoint.sv
module tb_pp_in_endpoint;
  localparam int BYTES = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fw_wr_valid = 1'b0, fw_arm = 1'b0, fw_clr_done = 1'b0, fw_clr_ovf = 1'b0;
  logic [7:0] fw_wr_data = '0;
  logic       usb_in_tok = 1'b0, usb_ack = 1'b0, tx_ready = 1'b1;
  logic       fw_wr_ready, st_pkt_ready, st_tx_done, st_overflow, irq;
  logic       rsp_nak, rsp_zlp, tx_valid, tx_last;
  logic [7:0] tx_data;

  pp_in_endpoint #(.BANK_BYTES(BYTES)) dut (.*);

  always #10 clk = ~clk;

  int vecs = 0, miss = 0, cyc = 0, nak_seen = 0, zlp_seen = 0;
  bit stall_en = 1'b0;
  logic [7:0] cap[$];

  // behavioural reference state
  logic [7:0] bq0[$], bq1[$];
  bit mv0, mv1, mdone, movf, mnak, mzlp, mrel, movf_hit;
  int mwp, mrp, mst, midx, msz;

  function automatic int qsize(int b);
    return (b == 0) ? bq0.size() : bq1.size();
  endfunction
  function automatic bit qvld(int b);
    return (b == 0) ? mv0 : mv1;
  endfunction
  function automatic logic [7:0] qbyte(int b, int i);
    if (b == 0) return (i < bq0.size()) ? bq0[i] : 8'h00;
    return (i < bq1.size()) ? bq1[i] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bq0.delete(); bq1.delete();
      mv0 = 0; mv1 = 0; mdone = 0; movf = 0; mnak = 0; mzlp = 0;
      mwp = 0; mrp = 0; mst = 0; midx = 0;
    end else begin
      mrel = 0; mnak = 0; mzlp = 0; movf_hit = 0;
      msz = qsize(mrp);
      if (mst == 1) begin
        if (tx_ready) begin
          if (midx == msz - 1) mst = 2;
          else midx++;
        end
      end else if (mst == 2 && usb_ack) begin
        mrel = 1; mst = 0;
      end else if (usb_in_tok) begin
        if (qvld(mrp)) begin
          midx = 0;
          if (msz == 0) begin mzlp = 1; mst = 2; end
          else mst = 1;
        end else mnak = 1;
      end
      if (fw_wr_valid && !qvld(mwp)) begin
        if (qsize(mwp) < BYTES) begin
          if (mwp == 0) bq0.push_back(fw_wr_data); else bq1.push_back(fw_wr_data);
        end else movf_hit = 1;
      end
      if (movf_hit) movf = 1;
      else if (fw_clr_ovf) movf = 0;
      if (fw_arm && !qvld(mwp)) begin
        if (mwp == 0) mv0 = 1; else mv1 = 1;
        mwp ^= 1;
      end
      if (mrel) begin
        if (mrp == 0) begin mv0 = 0; bq0.delete(); end
        else begin mv1 = 0; bq1.delete(); end
        mdone = 1; mrp ^= 1;
      end else if (fw_clr_done) mdone = 0;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      cmp("R6 tx_valid", int'(tx_valid), int'(mst == 1));
      if (mst == 1) begin
        cmp("R6 tx_last", int'(tx_last), int'(midx == qsize(mrp) - 1));
        cmp("R2 tx_data", int'(tx_data), int'(qbyte(mrp, midx)));
      end
      cmp("R5 rsp_nak", int'(rsp_nak), int'(mnak));
      cmp("R7 rsp_zlp", int'(rsp_zlp), int'(mzlp));
      cmp("R4 st_pkt_ready", int'(st_pkt_ready), int'(mv0 | mv1));
      cmp("R8 st_tx_done", int'(st_tx_done), int'(mdone));
      cmp("R8 irq", int'(irq), int'(mdone));
      cmp("R3 st_overflow", int'(st_overflow), int'(movf));
      if (tx_valid && tx_ready) cap.push_back(tx_data);
      if (rsp_nak) nak_seen++;
      if (rsp_zlp) zlp_seen++;
    end
  end

  always @(negedge clk) tx_ready <= stall_en ? (cyc % 3 != 0) : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      miss++; vecs++;
      $display("FAIL R6 watchdog act=%0d exp<%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(int n, int seed, ref logic [7:0] q[$]);
    for (int i = 0; i < n; i++) begin
      fw_wr_valid = 1'b1;
      fw_wr_data  = 8'(seed + i * 7);
      q.push_back(fw_wr_data);
      tick();
    end
    fw_wr_valid = 1'b0;
  endtask

  task automatic arm();   fw_arm = 1'b1;      tick(); fw_arm = 1'b0;      endtask
  task automatic tok();   usb_in_tok = 1'b1;  tick(); usb_in_tok = 1'b0;  endtask
  task automatic ack();   usb_ack = 1'b1;     tick(); usb_ack = 1'b0;     endtask
  task automatic clrd();  fw_clr_done = 1'b1; tick(); fw_clr_done = 1'b0; endtask

  task automatic run_pkt();
    int g = 0;
    cap.delete();
    tok();
    while (mst != 2 && g < 400) begin tick(); g++; end
    tick();
  endtask

  function automatic bit same(logic [7:0] a[$], logic [7:0] b[$]);
    if (a.size() != b.size()) return 0;
    foreach (a[i]) if (a[i] != b[i]) return 0;
    return 1;
  endfunction

  initial begin
    logic [7:0] ex_a[$], ex_b[$], ex_c[$], ex_d[$], ex_o[$], junk[$];
    int n0;
    tick(3);
    rst_n = 1'b1;
    tick();
    chk(!st_pkt_ready && !st_tx_done && !st_overflow && !irq && !tx_valid && !rsp_nak && !rsp_zlp,
        "R1 reset state", int'(st_pkt_ready | st_tx_done | irq | tx_valid), 0);

    n0 = nak_seen; tok(); tick();
    chk(nak_seen == n0 + 1, "R5 nak on empty", nak_seen - n0, 1);

    put(5, 8'h10, ex_a); arm();
    chk(st_pkt_ready, "R4 armed flag", int'(st_pkt_ready), 1);
    put(3, 8'h80, ex_b);
    stall_en = 1'b1;
    run_pkt();
    chk(same(cap, ex_a), "R2 bank0 payload", cap.size(), ex_a.size());
    chk(!st_tx_done, "R8 no done before ack", int'(st_tx_done), 0);
    ack(); tick();
    chk(st_tx_done && irq && !st_pkt_ready, "R8 release", int'(irq), 1);

    clrd(); arm();
    chk(!st_tx_done && st_pkt_ready, "R10 clear before arm", int'(st_pkt_ready), 1);
    run_pkt();
    chk(same(cap, ex_b), "R2 bank1 payload", cap.size(), ex_b.size());
    run_pkt();
    chk(same(cap, ex_b), "R9 replay from start", cap.size(), ex_b.size());
    ack(); tick();
    ack(); tick();
    chk(!st_pkt_ready && st_tx_done, "R9 stray ack ignored", int'(st_pkt_ready), 0);

    arm(); clrd();
    chk(st_pkt_ready, "R10 clear after arm keeps bank", int'(st_pkt_ready), 1);
    n0 = zlp_seen;
    run_pkt();
    chk(zlp_seen == n0 + 1 && cap.size() == 0, "R7 zero-length", zlp_seen - n0, 1);
    ack(); tick();

    put(70, 8'h33, ex_o);
    while (ex_o.size() > BYTES) void'(ex_o.pop_back());
    chk(st_overflow, "R3 overflow set", int'(st_overflow), 1);
    arm(); run_pkt();
    chk(same(cap, ex_o), "R3 capacity kept", cap.size(), BYTES);
    ack(); tick();
    fw_clr_ovf = 1'b1; tick(); fw_clr_ovf = 1'b0; tick();
    chk(!st_overflow, "R3 overflow cleared", int'(st_overflow), 0);

    put(4, 8'h51, ex_c); arm();
    put(2, 8'hA1, ex_d); arm();
    put(3, 8'hE0, junk); arm();
    cap.delete();
    tok(); tick(2);
    tok();
    while (mst != 2) tick();
    tick();
    chk(same(cap, ex_c), "R12 token mid-stream ignored", cap.size(), ex_c.size());
    usb_ack = 1'b1; fw_clr_done = 1'b1; tick(); usb_ack = 1'b0; fw_clr_done = 1'b0; tick();
    chk(st_tx_done, "R10 release beats clear", int'(st_tx_done), 1);
    run_pkt();
    chk(same(cap, ex_d), "R11 full-bank writes dropped", cap.size(), ex_d.size());
    ack(); tick();
    n0 = nak_seen; tok(); tick();
    chk(nak_seen == n0 + 1, "R5 nak after drain", nak_seen - n0, 1);
    stall_en = 1'b0;
    tick(3);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule